// File: doc/BRIEF.md
# Floating-Point Error Interrupt and Ignore-Error Latch Pair

This block sits between a processor's active-low floating-point error line and the system interrupt controller. When an error is flagged, an interrupt request latch sets and holds its output high. The error handler acknowledges by writing to a fixed I/O port. That write drops the request and sets a second latch. The second latch drives an active-low ignore-error line back to the processor, so the handler can run floating-point instructions while the error is still pending. The ignore latch resets when the processor clears its error conditions and the error line deasserts.

The ignore latch is state that software cannot see. Suppose management-mode code saves and then restores the floating-point state. The save clears the error, which drops the ignore latch. The restore raises the error again, but the ignore latch stays inactive, and the pending error would call the handler again. To prevent this, the block copies the ignore latch on management-mode entry and writes the copy back on exit. A parameter can turn the write-back off; that variant shows the failure.

Top module: `fperr_irq_glue`

## Requirements
- R1: The error line passes through a synchronizer of SYNC_STAGES (default 2) flops. An assertion edge of the synchronized error sets the interrupt request one clock later, when outside management mode. The request stays high until acknowledged or reset, whatever the error line does in the meantime.
- R2: A cycle with `io_wr` high and `io_addr` equal to ACK_PORT (default 16'h00F0) clears the interrupt request on that clock edge. If a new error edge arrives in the same cycle, the request stays set.
- R3: The same acknowledge write sets the ignore latch, so `fp_ignore_n` goes low on that clock edge.
- R4: A deassertion edge of the synchronized error clears the ignore latch (`fp_ignore_n` high). It takes priority over an acknowledge in the same cycle and also acts inside management mode.
- R5: A cycle with `io_wr` low, or with any address other than ACK_PORT, changes neither latch.
- R6: A `smm_enter` pulse stores the ignore latch value. With RESTORE_EN=1, a `smm_exit` pulse loads the stored value back into the ignore latch on that edge. With RESTORE_EN=0, exit leaves the latch as it is.
- R7: Error assertion edges inside management mode do not set the request. On `smm_exit`, if the synchronized error is active and the ignore latch is inactive after the exit update, the request sets on that edge; this is the handler re-trigger.
- R8: A synchronous active-high `rst` clears both latches and the stored copy, leaving `fp_irq` low and `fp_ignore_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_err_n | input | 1 | Asynchronous active-low floating-point error line |
| io_wr | input | 1 | I/O write cycle strobe, one clock per write |
| io_addr | input | ADDR_W (16) | I/O address of the current cycle |
| smm_enter | input | 1 | One-clock pulse on entry to management mode |
| smm_exit | input | 1 | One-clock pulse on exit from management mode |
| fp_irq | output | 1 | Interrupt request, active high, level held |
| fp_ignore_n | output | 1 | Ignore-error line to the processor, active low |

## Verification
The bench applies the same stimulus to two instances, one with the write-back enabled and one without. It plays the management-mode sequence: enter, error cleared, error raised again, exit. Without the write-back, `fp_ignore_n` stays high and the request fires again. A design that mishandled exit would show the same result on both instances. The bench lines up an acknowledge with a fresh error edge in the same cycle; a design that lets the clear win would lose that error. It also sends writes to a neighbouring port and cycles without a write; a loose address compare would drop the request early.

// File: rtl/fperr_pkg.sv
package fperr_pkg;
  // Events derived from the synchronized error line (active high).
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } err_evt_t;
endpackage

// File: rtl/fperr_sync.sv
module fperr_sync
  import fperr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     err_async_n,
  output err_evt_t evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= ~err_async_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], ~err_async_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  always_comb begin
    evt.level = chain[STAGES-1];
    evt.rise  = chain[STAGES-1] & ~prev_q;
    evt.fall  = ~chain[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/fperr_port_match.sv
module fperr_port_match #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ACK_PORT = 16'h00F0
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit
);
  assign hit = io_wr && (io_addr == ACK_PORT);
endmodule

// File: rtl/fperr_smm_hold.sv
module fperr_smm_hold (
  input  logic clk,
  input  logic rst,
  input  logic smm_enter,
  input  logic smm_exit,
  input  logic ign_now,
  output logic in_smm,
  output logic saved_ign
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_smm    <= 1'b0;
      saved_ign <= 1'b0;
    end else begin
      if (smm_enter) begin
        in_smm    <= 1'b1;
        saved_ign <= ign_now;
      end else if (smm_exit) begin
        in_smm    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fperr_irq_glue.sv
module fperr_irq_glue
  import fperr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ACK_PORT    = 16'h00F0,
  parameter int                SYNC_STAGES = 2,
  parameter bit                RESTORE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fp_err_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              smm_enter,
  input  logic              smm_exit,
  output logic              fp_irq,
  output logic              fp_ignore_n
);
  err_evt_t evt;
  logic     err_lvl, err_rise, err_fall;
  logic     ack_hit;
  logic     in_smm, saved_ign;
  logic     ign_now, ign_d, irq_d;
  logic     irq_q, ign_n_q;

  fperr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .err_async_n(fp_err_n), .evt(evt)
  );

  assign err_lvl  = evt.level;
  assign err_rise = evt.rise;
  assign err_fall = evt.fall;

  fperr_port_match #(.ADDR_W(ADDR_W), .ACK_PORT(ACK_PORT)) u_match (
    .io_wr(io_wr), .io_addr(io_addr), .hit(ack_hit)
  );

  assign ign_now = ~ign_n_q;

  fperr_smm_hold u_smm (
    .clk(clk), .rst(rst), .smm_enter(smm_enter), .smm_exit(smm_exit),
    .ign_now(ign_now), .in_smm(in_smm), .saved_ign(saved_ign)
  );

  // Ignore latch next state: exit write-back over error clear over acknowledge.
  generate
    if (RESTORE_EN) begin : g_restore
      always_comb begin
        ign_d = ign_now;
        if (ack_hit)  ign_d = 1'b1;
        if (err_fall) ign_d = 1'b0;
        if (smm_exit) ign_d = saved_ign;
      end
    end else begin : g_norestore
      always_comb begin
        ign_d = ign_now;
        if (ack_hit)  ign_d = 1'b1;
        if (err_fall) ign_d = 1'b0;
      end
    end
  endgenerate

  // Request next state: a new error beats the acknowledge clear.
  always_comb begin
    irq_d = irq_q;
    if (ack_hit)                          irq_d = 1'b0;
    if (err_rise && !in_smm)              irq_d = 1'b1;
    if (smm_exit && err_lvl && !ign_d)    irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      ign_n_q <= 1'b1;
    end else begin
      irq_q   <= irq_d;
      ign_n_q <= ~ign_d;
    end
  end

  assign fp_irq      = irq_q;
  assign fp_ignore_n = ign_n_q;
endmodule

// File: rtl/fperr_chk.sv
module fperr_chk #(
  parameter bit RESTORE_EN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic io_wr,
  input logic ack_hit,
  input logic err_rise,
  input logic err_fall,
  input logic in_smm,
  input logic smm_enter,
  input logic smm_exit,
  input logic fp_irq,
  input logic fp_ignore_n
);
  logic shadow;
  always_ff @(posedge clk) begin
    if (rst)            shadow <= 1'b0;
    else if (smm_enter) shadow <= !fp_ignore_n;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!fp_irq && fp_ignore_n)); // R8

  AST_EDGE_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (err_rise && !in_smm) |=> fp_irq); // R1

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !err_rise && !smm_exit) |=> !fp_irq); // R2

  AST_ACK_SETS_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !err_fall && !smm_exit) |=> !fp_ignore_n); // R3

  AST_FALL_CLEARS_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (err_fall && !smm_exit) |=> fp_ignore_n); // R4

  AST_NOWRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!io_wr && !err_fall && !smm_exit) |=> (fp_ignore_n == $past(fp_ignore_n))); // R5

  AST_SMM_NO_NEW_IRQ: assert property (@(posedge clk) disable iff (rst)
    (in_smm && !smm_exit && !err_rise) |=> !(fp_irq && !$past(fp_irq))); // R7

  generate
    if (RESTORE_EN) begin : g_rest_chk
      AST_EXIT_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (smm_exit && !smm_enter) |=> (fp_ignore_n == !shadow)); // R6
    end
  endgenerate
endmodule

bind fperr_irq_glue fperr_chk #(.RESTORE_EN(RESTORE_EN)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .ack_hit(ack_hit),
  .err_rise(err_rise), .err_fall(err_fall), .in_smm(in_smm),
  .smm_enter(smm_enter), .smm_exit(smm_exit),
  .fp_irq(fp_irq), .fp_ignore_n(fp_ignore_n)
);

// File: tb/tb_fperr_irq_glue.sv
module tb_fperr_irq_glue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fp_err_n = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        smm_enter = 1'b0;
  logic        smm_exit = 1'b0;
  logic        irq_a, ign_a, irq_b, ign_b;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fperr_irq_glue #(.RESTORE_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .fp_err_n(fp_err_n), .io_wr(io_wr), .io_addr(io_addr),
    .smm_enter(smm_enter), .smm_exit(smm_exit), .fp_irq(irq_a), .fp_ignore_n(ign_a)
  );

  fperr_irq_glue #(.RESTORE_EN(1'b0)) dut_nr (
    .clk(clk), .rst(rst), .fp_err_n(fp_err_n), .io_wr(io_wr), .io_addr(io_addr),
    .smm_enter(smm_enter), .smm_exit(smm_exit), .fp_irq(irq_b), .fp_ignore_n(ign_b)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one write cycle, sampled at the next posedge; leaves the bench at that negedge
  task automatic wr_cycle(input logic [15:0] a, input logic w);
    io_wr = w; io_addr = a;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3); rst = 1'b0;
    chk("R8 irq low after reset", irq_a, 1'b0);
    chk("R8 ignore high after reset", ign_a, 1'b1);
  endtask

  task automatic t_error_sets_irq;
    fp_err_n = 1'b0;
    step(2);
    chk("R1 no irq before sync delay", irq_a, 1'b0);
    step(1);
    chk("R1 irq set after sync", irq_a, 1'b1);
    chk("R1 irq set on second instance", irq_b, 1'b1);
    chk("R1 ignore still inactive", ign_a, 1'b1);
  endtask

  task automatic t_non_ack_ignored;
    wr_cycle(16'h00F0, 1'b0);
    wr_cycle(16'h00F1, 1'b1);
    wr_cycle(16'h01F0, 1'b1);
    step(1);
    chk("R5 irq kept by non-ack cycles", irq_a, 1'b1);
    chk("R5 ignore kept by non-ack cycles", ign_a, 1'b1);
  endtask

  task automatic t_ack;
    wr_cycle(16'h00F0, 1'b1);
    chk("R2 ack clears irq", irq_a, 1'b0);
    chk("R3 ack drives ignore low", ign_a, 1'b0);
    step(4);
    chk("R1 irq stays low without new edge", irq_a, 1'b0);
    chk("R5 ignore held with no write", ign_a, 1'b0);
  endtask

  task automatic t_smm_corner;
    smm_enter = 1'b1; step(1); smm_enter = 1'b0;
    fp_err_n = 1'b1; step(4);
    chk("R4 error clear drops ignore in smm", ign_a, 1'b1);
    chk("R4 error clear drops ignore (no restore)", ign_b, 1'b1);
    fp_err_n = 1'b0; step(4);
    chk("R7 no irq from edge inside smm", irq_a, 1'b0);
    chk("R7 no irq from edge inside smm (no restore)", irq_b, 1'b0);
    smm_exit = 1'b1; step(1); smm_exit = 1'b0;
    chk("R6 exit restores ignore active", ign_a, 1'b0);
    chk("R7 no re-trigger with restore", irq_a, 1'b0);
    chk("R6 without restore ignore stays inactive", ign_b, 1'b1);
    chk("R7 re-trigger without restore", irq_b, 1'b1);
    wr_cycle(16'h00F0, 1'b1);
    chk("R2 ack clears re-triggered irq", irq_b, 1'b0);
    chk("R3 ack sets ignore (no restore)", ign_b, 1'b0);
  endtask

  task automatic t_error_clear;
    fp_err_n = 1'b1; step(4);
    chk("R4 ignore released on error clear", ign_a, 1'b1);
    chk("R4 ignore released (no restore)", ign_b, 1'b1);
    chk("R1 irq unaffected by error clear", irq_a, 1'b0);
  endtask

  task automatic t_set_wins;
    fp_err_n = 1'b0;
    step(2);
    wr_cycle(16'h00F0, 1'b1);
    chk("R2 new error edge beats ack clear", irq_a, 1'b1);
    chk("R3 ack still sets ignore", ign_a, 1'b0);
  endtask

  task automatic t_reset_mid;
    rst = 1'b1; step(1); rst = 1'b0;
    chk("R8 reset clears irq", irq_a, 1'b0);
    chk("R8 reset releases ignore", ign_a, 1'b1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_error_sets_irq();
    t_non_ack_ignored();
    t_ack();
    t_smm_corner();
    t_error_clear();
    t_set_wins();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule